// File: doc/BRIEF.md
# Variable-Pass Multiplier Unit

This unit multiplies two 32-bit operands into a 64-bit result that is kept in a pair of 32-bit result registers, high and low. The arithmetic core is a single 32x16 array with radix-4 Booth recoding. The first operand always enters at full width. The second operand is consumed sixteen bits at a time. When the second operand fits in sixteen bits the array is used once. Otherwise it is used twice: the lower half first, then the upper half. The second partial product is shifted left by sixteen and added to the first.

A requester offers an operation on `issue_valid`. The operation is taken on any rising edge where `issue_ready` is also high. A 2-bit opcode selects signed or unsigned arithmetic, and selects whether the product overwrites the result pair or is added to it. Single-pass operations can be taken on every cycle. A two-pass operation holds the array for a second cycle, so `issue_ready` drops for one cycle behind it. This is what keeps two full-width multiplies from issuing on consecutive cycles. `res_done` pulses for one cycle when a new result is visible.

Top module: `varpass_mul`

## Requirements
- R1: While `rst` is high and after it falls, `res_hi` and `res_lo` are zero, `res_done` is low and `issue_ready` is high, until an operation completes.
- R2: Opcode 2'b00 (signed multiply) leaves {res_hi,res_lo} equal to the two's-complement 64-bit product of the operands, including when either operand is 32'h80000000.
- R3: Opcode 2'b01 (unsigned multiply) leaves {res_hi,res_lo} equal to the unsigned 64-bit product.
- R4: An operation whose second operand fits in 16 bits takes one pass. For signed opcodes (bit 0 = 0) this means bits 31:15 are all equal; for unsigned opcodes (bit 0 = 1) it means bits 31:16 are zero. The result and a `res_done` pulse are visible after the second rising edge counted from the accepting edge.
- R5: Any other operation takes two passes. Its result and `res_done` pulse appear one cycle later than for a single pass, and `res_done` stays low in between.
- R6: After a two-pass operation is accepted, `issue_ready` is low for exactly one cycle. After a single-pass operation it stays high, so single-pass operations can be accepted on consecutive edges.
- R7: Opcodes 2'b10 (signed) and 2'b11 (unsigned) add the product to the current {res_hi,res_lo}, modulo 2^64. Opcode bit 1 selects accumulate.
- R8: When no operation completes, {res_hi,res_lo} hold their value and `res_done` is low. An `issue_valid` presented while `issue_ready` is low is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Operation offered |
| issue_op | input | 2 | Bit 0: unsigned; bit 1: accumulate |
| issue_a | input | 32 | First operand, full width |
| issue_b | input | 32 | Second operand, decides the pass count |
| issue_ready | output | 1 | Operation taken on this edge if valid |
| res_done | output | 1 | One-cycle pulse: new result visible |
| res_hi | output | 32 | Upper 32 bits of result / accumulator |
| res_lo | output | 32 | Lower 32 bits of result / accumulator |

## Verification
The properties take for granted that the opcode and operands carry defined values whenever `issue_valid` is high. The pass-count and latency checks rely on this, because they evaluate the 16-bit fit rule on the offered second operand. They also assume that reset is applied for at least one edge before the first operation. The stimulus drives every input on the falling clock edge with known values and returns them to zero when idle. Operands cover the fit boundaries on both sides for signed and unsigned opcodes, and the most negative value.

// File: rtl/varpass_mul_pkg.sv
package varpass_mul_pkg;

    localparam int HALF_W = 16;
    localparam int MUL_W  = 2 * HALF_W;
    localparam int PROD_W = 2 * MUL_W;

    // bit 0: unsigned, bit 1: accumulate
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_MAC_S = 2'b10,
        OP_MAC_U = 2'b11
    } mul_op_e;

    typedef struct packed {
        mul_op_e            op;
        logic [MUL_W-1:0]   a;
        logic [MUL_W-1:0]   b;
        logic               wide;
    } mul_req_t;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    // second operand fits in one pass of the half-width array
    function automatic logic fits_half(input logic [MUL_W-1:0] b, input logic sgn);
        if (sgn)
            return (b[MUL_W-1:HALF_W-1] == '0) || (b[MUL_W-1:HALF_W-1] == '1);
        else
            return (b[MUL_W-1:HALF_W] == '0);
    endfunction

    // radix-4 digit from the window {y[2i+1], y[2i], y[2i-1]}
    function automatic booth_dig_t booth_decode(input logic [2:0] w);
        booth_dig_t d;
        d.neg = w[2] & ~(w[1] & w[0]);
        d.one = w[1] ^ w[0];
        d.two = (w == 3'b011) || (w == 3'b100);
        return d;
    endfunction

endpackage

// File: rtl/varpass_booth_array.sv
module varpass_booth_array
    import varpass_mul_pkg::*;
#(
    parameter int A_W = MUL_W,
    parameter int C_W = HALF_W,   // chunk width, even
    parameter int P_W = PROD_W
) (
    input  logic [A_W:0]   mcand,   // operand one, extended by one bit
    input  logic [C_W:0]   mplier,  // chunk, extended by one bit
    output logic [P_W-1:0] pp_sum
);
    localparam int Y_W  = C_W + 2;
    localparam int NDIG = Y_W / 2;

    logic [Y_W:0]   ywin;
    logic [P_W-1:0] mc_ext;
    logic [P_W-1:0] pp [NDIG];

    assign ywin   = {{(Y_W-C_W-1){mplier[C_W]}}, mplier, 1'b0};
    assign mc_ext = {{(P_W-A_W-1){mcand[A_W]}}, mcand};

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_dig
            booth_dig_t     d;
            logic [P_W-1:0] mag;
            logic [P_W-1:0] sgd;
            assign d   = booth_decode(ywin[2*i+2 -: 3]);
            assign mag = d.two ? (mc_ext << 1) : (d.one ? mc_ext : '0);
            assign sgd = d.neg ? (-mag) : mag;
            assign pp[i] = sgd << (2*i);
        end
    endgenerate

    always_comb begin
        pp_sum = '0;
        for (int i = 0; i < NDIG; i++)
            pp_sum = pp_sum + pp[i];
    end

endmodule

// File: rtl/varpass_issue_ctl.sv
module varpass_issue_ctl
    import varpass_mul_pkg::*;
#(
    parameter int A_W = MUL_W,
    parameter int C_W = HALF_W,
    parameter int P_W = PROD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [1:0]     in_op,
    input  logic [A_W-1:0] in_a,
    input  logic [A_W-1:0] in_b,
    output logic           ready,
    output logic [A_W:0]   arr_mcand,
    output logic [C_W:0]   arr_mplier,
    input  logic [P_W-1:0] arr_out,
    output logic [P_W-1:0] prod,
    output logic           wr_en,
    output logic           acc_en
);
    mul_req_t       st_q;
    logic           st_valid_q;
    logic           st_pass_q;
    logic [P_W-1:0] part_q;
    logic           accept;
    logic           sgn;
    logic           first_of_two;

    assign sgn          = ~st_q.op[0];
    assign first_of_two = st_valid_q && st_q.wide && !st_pass_q;
    assign ready        = !first_of_two;
    assign accept       = in_valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_valid_q <= 1'b0;
            st_pass_q  <= 1'b0;
            part_q     <= '0;
        end else begin
            if (accept) begin
                st_q.op    <= mul_op_e'(in_op);
                st_q.a     <= in_a;
                st_q.b     <= in_b;
                st_q.wide  <= !fits_half(in_b, ~in_op[0]);
                st_valid_q <= 1'b1;
                st_pass_q  <= 1'b0;
            end else if (first_of_two) begin
                st_pass_q  <= 1'b1;
            end else begin
                st_valid_q <= 1'b0;
                st_pass_q  <= 1'b0;
            end
            if (first_of_two)
                part_q <= arr_out;
        end
    end

    assign arr_mcand  = {sgn & st_q.a[A_W-1], st_q.a};
    assign arr_mplier = st_pass_q
        ? {sgn & st_q.b[A_W-1], st_q.b[A_W-1:C_W]}
        : {sgn & !st_q.wide & st_q.b[C_W-1], st_q.b[C_W-1:0]};

    assign prod   = st_q.wide ? (part_q + (arr_out << C_W)) : arr_out;
    assign wr_en  = st_valid_q && (!st_q.wide || st_pass_q);
    assign acc_en = st_q.op[1];

    // R6: one bubble behind a two-pass operation
    p_wide_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && !fits_half(in_b, ~in_op[0])) |=> !ready)
        else $error("p_wide_stall_r6");

    // R6: no bubble behind a single-pass operation
    p_narrow_free_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && fits_half(in_b, ~in_op[0])) |=> ready)
        else $error("p_narrow_free_r6");

    // R5: two-pass write lands two cycles after acceptance, not one
    p_two_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && !fits_half(in_b, ~in_op[0])) |=> (!wr_en ##1 wr_en))
        else $error("p_two_pass_r5");

endmodule

// File: rtl/varpass_result_acc.sv
module varpass_result_acc
    import varpass_mul_pkg::*;
#(
    parameter int P_W = PROD_W,
    localparam int H_W = P_W / 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           acc_en,
    input  logic [P_W-1:0] prod,
    output logic [H_W-1:0] hi,
    output logic [H_W-1:0] lo,
    output logic           done
);
    logic [P_W-1:0] hilo_q;
    logic           done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hilo_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= wr_en;
            if (wr_en)
                hilo_q <= (acc_en ? hilo_q : '0) + prod;
        end
    end

    assign hi   = hilo_q[P_W-1:H_W];
    assign lo   = hilo_q[H_W-1:0];
    assign done = done_q;

    // R8: result pair untouched when nothing completes
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable({hi, lo}) && !done))
        else $error("p_hold_r8");

    // R2: plain multiply overwrites the pair
    p_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !acc_en) |=> ({hi, lo} == $past(prod)))
        else $error("p_overwrite_r2");

    // R7: accumulate adds onto the previous pair
    p_accum_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_en) |=> ({hi, lo} == $past({hi, lo}) + $past(prod)))
        else $error("p_accum_r7");

endmodule

// File: rtl/varpass_mul.sv
module varpass_mul
    import varpass_mul_pkg::*;
#(
    parameter int A_W = MUL_W,
    parameter int C_W = HALF_W,
    localparam int P_W = 2 * A_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           issue_valid,
    input  logic [1:0]     issue_op,
    input  logic [A_W-1:0] issue_a,
    input  logic [A_W-1:0] issue_b,
    output logic           issue_ready,
    output logic           res_done,
    output logic [A_W-1:0] res_hi,
    output logic [A_W-1:0] res_lo
);
    logic [A_W:0]   arr_mcand;
    logic [C_W:0]   arr_mplier;
    logic [P_W-1:0] arr_out;
    logic [P_W-1:0] prod;
    logic           wr_en;
    logic           acc_en;

    varpass_issue_ctl #(.A_W(A_W), .C_W(C_W), .P_W(P_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (issue_valid),
        .in_op      (issue_op),
        .in_a       (issue_a),
        .in_b       (issue_b),
        .ready      (issue_ready),
        .arr_mcand  (arr_mcand),
        .arr_mplier (arr_mplier),
        .arr_out    (arr_out),
        .prod       (prod),
        .wr_en      (wr_en),
        .acc_en     (acc_en)
    );

    varpass_booth_array #(.A_W(A_W), .C_W(C_W), .P_W(P_W)) u_arr (
        .mcand  (arr_mcand),
        .mplier (arr_mplier),
        .pp_sum (arr_out)
    );

    varpass_result_acc #(.P_W(P_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .acc_en (acc_en),
        .prod   (prod),
        .hi     (res_hi),
        .lo     (res_lo),
        .done   (res_done)
    );

    logic narrow_acc;
    assign narrow_acc = issue_valid && issue_ready && fits_half(issue_b, ~issue_op[0]);

    // R4: single-pass result visible two edges after acceptance
    p_narrow_latency_r4: assert property (@(posedge clk) disable iff (rst)
        narrow_acc |-> ##2 res_done)
        else $error("p_narrow_latency_r4");

    // R5: two-pass result visible three edges after acceptance
    p_wide_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && !fits_half(issue_b, ~issue_op[0])) |-> ##3 res_done)
        else $error("p_wide_latency_r5");

endmodule

// File: tb/sim_varpass_mul.sv
module sim_varpass_mul;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        rdy, done;
    logic [31:0] hi, lo;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [63:0] model = '0;

    always #2.5 clk = ~clk;

    varpass_mul u0 (
        .clk(clk), .rst(rst), .issue_valid(valid), .issue_op(op_i),
        .issue_a(a_i), .issue_b(b_i), .issue_ready(rdy),
        .res_done(done), .res_hi(hi), .res_lo(lo)
    );

    // {op, a, b, expected passes}
    localparam int NVEC = 13;
    localparam logic [67:0] VEC [NVEC] = '{
        {2'b00, 32'h0000_0007, 32'h0000_0006, 2'd1},
        {2'b00, 32'h8000_0000, 32'h0000_7FFF, 2'd1},
        {2'b00, 32'h8000_0000, 32'hFFFF_8000, 2'd1},
        {2'b00, 32'h8000_0000, 32'h8000_0000, 2'd2},
        {2'b00, 32'h1234_5678, 32'h0000_8000, 2'd2},
        {2'b00, 32'hFFFF_FFFF, 32'h0001_0000, 2'd2},
        {2'b01, 32'hFFFF_FFFF, 32'h0000_FFFF, 2'd1},
        {2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2},
        {2'b01, 32'h8000_0000, 32'h0001_0000, 2'd2},
        {2'b10, 32'hFFFF_FFFF, 32'h0000_0005, 2'd1},
        {2'b11, 32'hDEAD_BEEF, 32'hCAFE_F00D, 2'd2},
        {2'b10, 32'h7FFF_FFFF, 32'h8000_0000, 2'd2},
        {2'b00, 32'h0000_0000, 32'h1234_5678, 2'd2}
    };

    function automatic logic [63:0] ref_prod(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ax, bx;
        ax = op[0] ? {32'b0, a} : {{32{a[31]}}, a};
        bx = op[0] ? {32'b0, b} : {{32{b[31]}}, b};
        return ax * bx;
    endfunction

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b00:   return "R2";
            2'b01:   return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // drive one operation and follow it to completion
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input int np);
        logic [63:0] exp;
        exp = (op[1] ? model : 64'd0) + ref_prod(op, a, b);
        @(negedge clk);
        check(rdy == 1'b1, "R6 ready before issue", {63'd0, rdy}, 64'd1);
        valid = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);                       // accepting edge passed
        valid = 1'b0; a_i = '0; b_i = '0; op_i = 2'b00;
        check(done == 1'b0, "R4 done low in accept cycle", {63'd0, done}, 64'd0);
        if (np == 2) begin
            check(rdy == 1'b0, "R6 bubble after two-pass", {63'd0, rdy}, 64'd0);
            @(negedge clk);
            check(done == 1'b0, "R5 done low between passes", {63'd0, done}, 64'd0);
            check(rdy == 1'b1, "R6 bubble lasts one cycle", {63'd0, rdy}, 64'd1);
        end else begin
            check(rdy == 1'b1, "R6 no bubble after one-pass", {63'd0, rdy}, 64'd1);
        end
        @(negedge clk);
        check(done == 1'b1, np == 2 ? "R5 done at two-pass latency" : "R4 done at one-pass latency",
              {63'd0, done}, 64'd1);
        check({hi, lo} == exp, tag_of(op), {hi, lo}, exp);
        model = exp;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [67:0] v;
        logic [63:0] w1, w2, keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({hi, lo} == 64'd0, "R1 pair zero in reset", {hi, lo}, 64'd0);
        check(done == 1'b0, "R1 done low in reset", {63'd0, done}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rdy == 1'b1, "R1 ready after reset", {63'd0, rdy}, 64'd1);
        check({hi, lo} == 64'd0, "R1 pair zero after reset", {hi, lo}, 64'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            run_op(v[67:66], v[65:34], v[33:2], int'(v[1:0]));
        end

        // R6/R7: three single-pass ops on consecutive edges, chained accumulate
        @(negedge clk);
        valid = 1'b1; op_i = 2'b00; a_i = 32'd3; b_i = 32'd4;
        @(negedge clk);
        check(rdy == 1'b1, "R6 back-to-back narrow ready", {63'd0, rdy}, 64'd1);
        op_i = 2'b10; a_i = 32'd5; b_i = 32'd6;
        @(negedge clk);
        check({hi, lo} == 64'd12, "R2 first of chain", {hi, lo}, 64'd12);
        check(done == 1'b1, "R4 first of chain done", {63'd0, done}, 64'd1);
        check(rdy == 1'b1, "R6 still ready in chain", {63'd0, rdy}, 64'd1);
        op_i = 2'b11; a_i = 32'd7; b_i = 32'd8;
        @(negedge clk);
        valid = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
        check({hi, lo} == 64'd42, "R7 second of chain", {hi, lo}, 64'd42);
        @(negedge clk);
        check({hi, lo} == 64'd98, "R7 third of chain", {hi, lo}, 64'd98);
        check(done == 1'b1, "R4 third of chain done", {63'd0, done}, 64'd1);
        @(negedge clk);
        check(done == 1'b0, "R8 done drops when idle", {63'd0, done}, 64'd0);
        check({hi, lo} == 64'd98, "R8 pair holds when idle", {hi, lo}, 64'd98);

        // R6: two full-width multiplies back to back are interlocked
        w1 = ref_prod(2'b00, 32'h8765_4321, 32'hF00D_1234);
        w2 = ref_prod(2'b01, 32'hA5A5_A5A5, 32'h5A5A_0001);
        @(negedge clk);
        valid = 1'b1; op_i = 2'b00; a_i = 32'h8765_4321; b_i = 32'hF00D_1234;
        @(negedge clk);
        op_i = 2'b01; a_i = 32'hA5A5_A5A5; b_i = 32'h5A5A_0001;
        check(rdy == 1'b0, "R6 second wide stalled", {63'd0, rdy}, 64'd0);
        @(negedge clk);
        check(rdy == 1'b1, "R6 stall released", {63'd0, rdy}, 64'd1);
        check(done == 1'b0, "R5 first wide not yet done", {63'd0, done}, 64'd0);
        @(negedge clk);
        valid = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
        check({hi, lo} == w1, "R2 first wide result", {hi, lo}, w1);
        check(rdy == 1'b0, "R6 second wide bubble", {63'd0, rdy}, 64'd0);
        @(negedge clk);
        check(done == 1'b0, "R5 second wide mid-pass", {63'd0, done}, 64'd0);
        check({hi, lo} == w1, "R8 pair held mid-pass", {hi, lo}, w1);
        @(negedge clk);
        check({hi, lo} == w2, "R3 second wide result", {hi, lo}, w2);
        check(done == 1'b1, "R5 second wide done", {63'd0, done}, 64'd1);

        // R8: request offered only during the stall is not taken
        keep = 64'h0000_0002_0000_0000;
        @(negedge clk);
        valid = 1'b1; op_i = 2'b00; a_i = 32'h0001_0000; b_i = 32'h0002_0000;
        @(negedge clk);
        op_i = 2'b10; a_i = 32'd9; b_i = 32'd9;
        check(rdy == 1'b0, "R8 stall cycle", {63'd0, rdy}, 64'd0);
        @(negedge clk);
        valid = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
        @(negedge clk);
        check({hi, lo} == keep, "R8 wide result only", {hi, lo}, keep);
        @(negedge clk);
        check(done == 1'b0, "R8 stalled request ignored (done)", {63'd0, done}, 64'd0);
        check({hi, lo} == keep, "R8 stalled request ignored (pair)", {hi, lo}, keep);

        // R1: reset in the middle of a run clears the pair
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check({hi, lo} == 64'd0, "R1 pair cleared by reset", {hi, lo}, 64'd0);
        check(rdy == 1'b1, "R1 ready after second reset", {63'd0, rdy}, 64'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule